// File: doc/BRIEF.md
# Clock-Master Command/Reply SPI Link Controller

This block sits on the FPGA side of a link to a microcontroller. The FPGA generates the serial clock, but the microcontroller decides when a transaction happens. The microcontroller pulls its active-low request line low. The controller answers by raising a busy flag. It then clocks a fixed-length command in from the microcontroller on MISO and presents the command to local execution logic.

When the execution logic returns a reply, the controller holds that reply until the microcontroller releases its request line. Only then does it clock the reply out on MOSI. Busy drops on the last serial clock falling edge of the reply, and the falling edge of busy tells the microcontroller that the exchange is over. The microcontroller may release the request at any time after busy rises.

The serial clock follows SPI mode 0: it idles low, data is sampled on the rising edge and changes while the clock is low. The clock half-period is a parameter, so the link can be slowed down when the return path has a long delay.

Top module: `hostlink_spi_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, busy_o, sck_o, mosi_o and cmd_valid_o are all low. A reset asserted in the middle of a transaction abandons it.
- R2: req_n_i is active-low and passes through a SYNC_STAGES-flop synchronizer. With the default of 2 stages, busy_o rises on the third clock edge after req_n_i is first sampled low. It always rises within 25 cycles.
- R3: sck_o is low whenever busy_o is low. While bits are shifted, each high phase of sck_o lasts exactly SCK_DIV system cycles.
- R4: The command is CMD_BYTES*8 bits long and arrives MSB first. MISO is sampled in the cycle where sck_o rises. The first bit received lands in the top bit of cmd_data_o. cmd_valid_o rises after the last command bit and stays high, with sck_o low, until a reply is accepted.
- R5: A reply is accepted on a clock edge where rsp_valid_i and cmd_valid_o are both high, and cmd_valid_o is low afterwards. A value of rsp_len_i above RSP_MAX_BYTES is treated as RSP_MAX_BYTES.
- R6: No reply clock pulse is issued while the synchronized request is still asserted. The reply starts only after req_n_i has been seen high.
- R7: Reply bytes go out on MOSI MSB first, starting at rsp_data_i bit RSP_MAX_BYTES*8-1. mosi_o changes only in cycles where sck_o is low. mosi_o is 0 during the command phase.
- R8: busy_o falls in the same cycle that sck_o falls for the last reply bit. A reply length of 0 clears busy_o, with no reply pulses, once the request is released. After busy_o falls, sck_o and mosi_o are low.
- R9: A release and re-assertion of req_n_i while busy_o is high does not restart or disturb the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_o | output | 1 | Serial clock driven to the microcontroller |
| mosi_o | output | 1 | Reply data toward the microcontroller |
| miso_i | input | 1 | Command data from the microcontroller |
| req_n_i | input | 1 | Active-low transaction request from the microcontroller |
| busy_o | output | 1 | High from request acceptance until the reply is complete |
| cmd_valid_o | output | 1 | Command held on cmd_data_o, waiting for a reply |
| cmd_data_o | output | CMD_BYTES*8 | Received command, first bit in the MSB |
| rsp_valid_i | input | 1 | Reply offered by the execution logic |
| rsp_data_i | input | RSP_MAX_BYTES*8 | Reply bytes, first byte in the top bits |
| rsp_len_i | input | $clog2(RSP_MAX_BYTES+1) | Number of reply bytes to send |

## Verification
The assertions check on every cycle the rules that hold at all times:
- the request-to-busy latency bound;
- SCK idling low outside busy;
- the exact width of each SCK high phase;
- MOSI changing only while SCK is low;
- the absence of SCK while a command waits for its reply;
- a reply starting only with the request released;
- busy closing with SCK low.

Whether the command bits are assembled in the right order, whether the reply bits and their count match the requested length (including the clamp and the zero-length case), and whether a mid-command request glitch or a reset mid-transaction is survived can only be shown by the bench's scenarios. The bench plays the microcontroller there and compares whole transactions.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;

    typedef enum logic [2:0] {
        LNK_IDLE,
        LNK_CMD,
        LNK_EXEC,
        LNK_HOLD,
        LNK_RSP
    } lnk_state_e;

endpackage

// File: rtl/hostlink_sync.sv
module hostlink_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_i;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hostlink_shifter.sv
module hostlink_shifter #(
    parameter int FRAME_W = 32,
    parameter int DIV     = 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   nbits_i,
    input  logic [FRAME_W-1:0] tx_word_i,
    input  logic               miso_i,
    output logic               sck_o,
    output logic               mosi_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] rx_word_o
);

    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    typedef struct packed {
        logic               active;
        logic               sck;
        logic               mosi;
        logic [DIV_W-1:0]   div_cnt;
        logic [CNT_W-1:0]   bits_left;
        logic [FRAME_W-1:0] shreg;
    } shf_t;

    shf_t shf_d, shf_q;
    logic done_d;

    always_comb begin
        shf_d  = shf_q;
        done_d = 1'b0;
        if (!shf_q.active) begin
            if (start_i) begin
                shf_d.active    = 1'b1;
                shf_d.sck       = 1'b0;
                shf_d.div_cnt   = '0;
                shf_d.bits_left = nbits_i;
                shf_d.shreg     = tx_word_i;
                shf_d.mosi      = tx_word_i[FRAME_W-1];
            end
        end else if (shf_q.div_cnt == DIV_LAST) begin
            shf_d.div_cnt = '0;
            if (!shf_q.sck) begin
                // rising edge: capture the incoming bit
                shf_d.sck   = 1'b1;
                shf_d.shreg = {shf_q.shreg[FRAME_W-2:0], miso_i};
            end else begin
                // falling edge: present the next outgoing bit
                shf_d.sck       = 1'b0;
                shf_d.bits_left = shf_q.bits_left - 1'b1;
                if (shf_q.bits_left == CNT_W'(1)) begin
                    shf_d.active = 1'b0;
                    shf_d.mosi   = 1'b0;
                    done_d       = 1'b1;
                end else begin
                    shf_d.mosi = shf_q.shreg[FRAME_W-1];
                end
            end
        end else begin
            shf_d.div_cnt = shf_q.div_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign sck_o     = shf_q.sck;
    assign mosi_o    = shf_q.mosi;
    assign done_o    = done_d;
    assign rx_word_o = shf_q.shreg;

endmodule

// File: rtl/hostlink_spi_ctrl.sv
module hostlink_spi_ctrl #(
    parameter int CMD_BYTES     = 2,
    parameter int RSP_MAX_BYTES = 4,
    parameter int SCK_DIV       = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int CMD_W         = CMD_BYTES * 8,
    parameter int RSP_W         = RSP_MAX_BYTES * 8,
    parameter int LEN_W         = $clog2(RSP_MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             sck_o,
    output logic             mosi_o,
    input  logic             miso_i,
    input  logic             req_n_i,
    output logic             busy_o,
    output logic             cmd_valid_o,
    output logic [CMD_W-1:0] cmd_data_o,
    input  logic             rsp_valid_i,
    input  logic [RSP_W-1:0] rsp_data_i,
    input  logic [LEN_W-1:0] rsp_len_i
);
    import hostlink_pkg::*;

    localparam int FRAME_W = (CMD_W > RSP_W) ? CMD_W : RSP_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int PAD_W   = FRAME_W - RSP_W;
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(RSP_MAX_BYTES);

    typedef struct packed {
        lnk_state_e       state;
        logic             busy;
        logic [CMD_W-1:0] cmd;
        logic [RSP_W-1:0] rsp;
        logic [LEN_W-1:0] len;
    } lnk_t;

    lnk_t lnk_d, lnk_q;

    logic               req_sync_n;
    logic               req_act;
    logic               eng_start;
    logic [CNT_W-1:0]   eng_nbits;
    logic [FRAME_W-1:0] eng_tx;
    logic               eng_done;
    logic [FRAME_W-1:0] eng_rx;

    hostlink_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_n_i),
        .q_o   (req_sync_n)
    );

    assign req_act = ~req_sync_n;

    hostlink_shifter #(
        .FRAME_W (FRAME_W),
        .DIV     (SCK_DIV),
        .CNT_W   (CNT_W)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (eng_start),
        .nbits_i   (eng_nbits),
        .tx_word_i (eng_tx),
        .miso_i    (miso_i),
        .sck_o     (sck_o),
        .mosi_o    (mosi_o),
        .done_o    (eng_done),
        .rx_word_o (eng_rx)
    );

    always_comb begin
        lnk_d     = lnk_q;
        eng_start = 1'b0;
        eng_nbits = '0;
        eng_tx    = '0;
        unique case (lnk_q.state)
            LNK_IDLE: begin
                if (req_act) begin
                    lnk_d.busy  = 1'b1;
                    lnk_d.state = LNK_CMD;
                    eng_start   = 1'b1;
                    eng_nbits   = CNT_W'(CMD_W);
                end
            end
            LNK_CMD: begin
                if (eng_done) begin
                    lnk_d.cmd   = eng_rx[CMD_W-1:0];
                    lnk_d.state = LNK_EXEC;
                end
            end
            LNK_EXEC: begin
                if (rsp_valid_i) begin
                    lnk_d.rsp   = rsp_data_i;
                    lnk_d.len   = (rsp_len_i > LEN_MAX) ? LEN_MAX : rsp_len_i;
                    lnk_d.state = LNK_HOLD;
                end
            end
            LNK_HOLD: begin
                if (!req_act) begin
                    if (lnk_q.len == '0) begin
                        lnk_d.busy  = 1'b0;
                        lnk_d.state = LNK_IDLE;
                    end else begin
                        eng_start   = 1'b1;
                        eng_nbits   = CNT_W'({lnk_q.len, 3'b000});
                        eng_tx      = FRAME_W'(lnk_q.rsp) << PAD_W;
                        lnk_d.state = LNK_RSP;
                    end
                end
            end
            LNK_RSP: begin
                if (eng_done) begin
                    lnk_d.busy  = 1'b0;
                    lnk_d.state = LNK_IDLE;
                end
            end
            default: begin
                lnk_d.busy  = 1'b0;
                lnk_d.state = LNK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lnk_q       <= '0;
            lnk_q.state <= LNK_IDLE;
        end else begin
            lnk_q <= lnk_d;
        end
    end

    assign busy_o      = lnk_q.busy;
    assign cmd_valid_o = (lnk_q.state == LNK_EXEC);
    assign cmd_data_o  = lnk_q.cmd;

endmodule

// File: rtl/hostlink_spi_chk.sv
module hostlink_spi_chk #(
    parameter int SCK_DIV = 4,
    parameter int LAT_MAX = 25
) (
    input logic clk,
    input logic rst_n,
    input logic sck_o,
    input logic mosi_o,
    input logic req_n_i,
    input logic busy_o,
    input logic cmd_valid_o,
    input logic rsp_valid_i
);

    localparam int HW = $clog2(SCK_DIV + 2) + 1;
    localparam int LW = $clog2(LAT_MAX + 2) + 1;

    logic [HW-1:0] hi_cnt;
    logic [LW-1:0] lat_cnt;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            lat_cnt <= '0;
            armed   <= 1'b0;
        end else begin
            if (!sck_o)                      hi_cnt <= '0;
            else if (hi_cnt != {HW{1'b1}})   hi_cnt <= hi_cnt + 1'b1;

            if (busy_o || req_n_i)           lat_cnt <= '0;
            else if (lat_cnt != {LW{1'b1}})  lat_cnt <= lat_cnt + 1'b1;

            if (!busy_o)                     armed <= 1'b0;
            else if (cmd_valid_o && rsp_valid_i) armed <= 1'b1;
        end
    end

    AST_BUSY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lat_cnt <= LW'(LAT_MAX));                                          // R2
    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sck_o);                                               // R3
    AST_SCK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |-> hi_cnt == HW'(SCK_DIV));                          // R3
    AST_CMD_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (!sck_o && busy_o));                               // R4
    AST_REPLY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(sck_o)) |-> req_n_i);                              // R6
    AST_MOSI_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi_o) |-> !sck_o);                                      // R7
    AST_BUSY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (!sck_o && !mosi_o && !cmd_valid_o));           // R8

endmodule

bind hostlink_spi_ctrl hostlink_spi_chk #(
    .SCK_DIV (SCK_DIV),
    .LAT_MAX (25)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .req_n_i     (req_n_i),
    .busy_o      (busy_o),
    .cmd_valid_o (cmd_valid_o),
    .rsp_valid_i (rsp_valid_i)
);

// File: tb/hostlink_spi_ctrl_bench.sv
module hostlink_spi_ctrl_bench;

    localparam int CMD_BYTES = 2;
    localparam int RSP_MAX   = 4;
    localparam int DIV       = 3;
    localparam int CMD_W     = CMD_BYTES * 8;
    localparam int RSP_W     = RSP_MAX * 8;
    localparam int LEN_W     = $clog2(RSP_MAX + 1);
    localparam int NVEC      = 6;

    // {cmd[52:37], rsp[36:5], len[4:2], early_release[1], req_glitch[0]}
    localparam logic [52:0] VECS [NVEC] = '{
        {16'hA55A, 32'hDEADBEEF, 3'd4, 1'b0, 1'b0},
        {16'h0001, 32'h81000000, 3'd1, 1'b1, 1'b0},
        {16'hFFFF, 32'h12345678, 3'd2, 1'b0, 1'b1},
        {16'h8000, 32'hC3C3C3C3, 3'd3, 1'b1, 1'b0},
        {16'h3C96, 32'h55AA55AA, 3'd0, 1'b0, 1'b0},
        {16'h7E81, 32'hF0E1D2C3, 3'd7, 1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sck_o, mosi_o, miso_i;
    logic             req_n_i = 1'b1;
    logic             busy_o, cmd_valid_o;
    logic [CMD_W-1:0] cmd_data_o;
    logic             rsp_valid_i = 1'b0;
    logic [RSP_W-1:0] rsp_data_i = '0;
    logic [LEN_W-1:0] rsp_len_i = '0;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;
    int rise_cnt = 0;
    int fall_cnt = 0;
    int fall_base = 0;
    int t_rise   = 0;
    int hi_bad   = 0;
    logic [63:0]      cap = '0;
    logic [CMD_W-1:0] mcu_tx = '0;

    hostlink_spi_ctrl #(
        .CMD_BYTES     (CMD_BYTES),
        .RSP_MAX_BYTES (RSP_MAX),
        .SCK_DIV       (DIV),
        .SYNC_STAGES   (2)
    ) u_hostlink_spi_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_o       (sck_o),
        .mosi_o      (mosi_o),
        .miso_i      (miso_i),
        .req_n_i     (req_n_i),
        .busy_o      (busy_o),
        .cmd_valid_o (cmd_valid_o),
        .cmd_data_o  (cmd_data_o),
        .rsp_valid_i (rsp_valid_i),
        .rsp_data_i  (rsp_data_i),
        .rsp_len_i   (rsp_len_i)
    );

    initial forever #5 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    // microcontroller model: samples MOSI on rising SCK, advances MISO on falling SCK
    always @(posedge sck_o) begin
        rise_cnt = rise_cnt + 1;
        cap      = {cap[62:0], mosi_o};
        t_rise   = cyc;
    end

    always @(negedge sck_o) begin
        fall_cnt = fall_cnt + 1;
        if (cyc - t_rise != DIV) hi_bad = hi_bad + 1;
    end

    assign miso_i = ((fall_cnt - fall_base) < CMD_W) ?
                    mcu_tx[CMD_W-1-(fall_cnt - fall_base)] : 1'b1;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input logic [15:0] cmd, input logic [31:0] rsp,
                           input logic [2:0] len, input bit early, input bit glitch);
        int lat, n, rb, t;
        logic [63:0] mask, exp_r;
        n = (len > 3'd4) ? 4 : int'(len);
        mcu_tx    = cmd;
        fall_base = fall_cnt;
        rb        = rise_cnt;
        @(negedge clk);
        req_n_i = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!busy_o && lat < 40);
        check(lat == 3, "R2 busy latency", 64'(lat), 64'd3);
        if (early) req_n_i = 1'b1;
        if (glitch) begin
            repeat (4) @(negedge clk);
            req_n_i = 1'b1;
            repeat (6) @(negedge clk);
            req_n_i = 1'b0;
        end
        t = 0;
        while (!cmd_valid_o && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(cmd_valid_o && busy_o, "R4 cmd_valid raised", 64'(cmd_valid_o), 64'd1);
        check(cmd_data_o == cmd, "R4 R9 command word", 64'(cmd_data_o), 64'(cmd));
        check(rise_cnt - rb == CMD_W, "R4 command pulses", 64'(rise_cnt - rb), 64'(CMD_W));
        check(cap[15:0] == 16'h0, "R7 mosi zero in command", cap[15:0], 64'd0);
        repeat (3) @(negedge clk);
        check(cmd_valid_o && !sck_o && rise_cnt - rb == CMD_W, "R4 quiet while waiting",
              64'(rise_cnt - rb), 64'(CMD_W));
        rsp_valid_i = 1'b1;
        rsp_data_i  = rsp;
        rsp_len_i   = len;
        @(negedge clk);
        rsp_valid_i = 1'b0;
        check(!cmd_valid_o, "R5 reply accepted", 64'(cmd_valid_o), 64'd0);
        if (!early) begin
            repeat (20) @(negedge clk);
            check(busy_o && rise_cnt - rb == CMD_W, "R6 reply held for release",
                  64'(rise_cnt - rb), 64'(CMD_W));
            req_n_i = 1'b1;
        end
        t = 0;
        while (busy_o && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(!busy_o, "R8 busy cleared", 64'(busy_o), 64'd0);
        check(rise_cnt - rb == CMD_W + n * 8, "R5 R8 total pulses",
              64'(rise_cnt - rb), 64'(CMD_W + n * 8));
        if (n > 0) begin
            mask  = (64'd1 << (n * 8)) - 64'd1;
            exp_r = 64'(rsp >> (32 - n * 8));
            check((cap & mask) == exp_r, "R7 reply bits", cap & mask, exp_r);
        end
        check(!sck_o && !mosi_o, "R8 lines idle after close",
              {62'd0, sck_o, mosi_o}, 64'd0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy_o && !sck_o && !mosi_o && !cmd_valid_o, "R1 outputs in reset",
              {60'd0, busy_o, sck_o, mosi_o, cmd_valid_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !sck_o && !mosi_o && !cmd_valid_o, "R1 outputs after reset",
              {60'd0, busy_o, sck_o, mosi_o, cmd_valid_o}, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            run_txn(VECS[i][52:37], VECS[i][36:5], VECS[i][4:2], VECS[i][1], VECS[i][0]);
        end

        check(hi_bad == 0 && rise_cnt > 0, "R3 sck high width", 64'(hi_bad), 64'd0);

        // R1: reset in the middle of a command aborts the transaction
        mcu_tx    = 16'h1234;
        fall_base = fall_cnt;
        @(negedge clk);
        req_n_i = 1'b0;
        repeat (20) @(negedge clk);
        check(busy_o, "R1 transaction started before reset", 64'(busy_o), 64'd1);
        rst_n   = 1'b0;
        req_n_i = 1'b1;
        @(negedge clk);
        check(!busy_o && !sck_o && !mosi_o, "R1 abort on reset",
              {61'd0, busy_o, sck_o, mosi_o}, 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // back-to-back transaction after the abort
        run_txn(16'h5AA5, 32'h0F1E2D3C, 3'd2, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_checks + 1);
        $finish;
    end

endmodule